// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This unit performs one integer operation on a destination operand and a second operand each time it is given one. It supports wrapping add, subtract and multiply, unsigned divide and remainder, bitwise OR, AND and XOR, move, negate, left shift, logical right shift, arithmetic right shift and byte reordering. A mode flag picks 64-bit or 32-bit operation. In 32-bit mode only the low halves of the operands are used, and the upper half of the result is cleared.

A register file or issue stage supplies the destination value, the source register value, a 32-bit immediate and an operation code. It asserts `in_valid` for one cycle per operation. The unit registers the result and presents it one clock later with `out_valid`, so it can be driven back-to-back every cycle. Divide and remainder by zero do not trap: each gives a defined value. The immediate is zero-extended in 32-bit mode and sign-extended in 64-bit mode.

Top module: `exu_core`

## Requirements
- R1: After reset `out_valid` is 0 and `out_result` is 0. An operation presented with `in_valid` high appears on `out_result` with `out_valid` high at the next rising edge. A cycle with `in_valid` low gives `out_valid` low on the next edge and leaves `out_result` unchanged.
- R2: `src_is_reg`=1 takes the second operand from `src_val`. `src_is_reg`=0 takes it from `imm_val`: sign-extended to 64 bits when `wide_mode`=1, zero-extended when `wide_mode`=0. Unsigned divide and remainder therefore see an all-ones immediate as 2^64-1 in 64-bit mode and as 2^32-1 in 32-bit mode.
- R3: When `wide_mode`=0 and the code is not 0xd, 0xe or 0xf, the operation uses bits 31:0 of both operands and bits 63:32 of the result are 0.
- R4: Codes 0x0 (add), 0x1 (subtract) and 0x2 (multiply, low half of the product) wrap modulo 2^64 or 2^32 depending on the mode.
- R5: Code 0x3 gives the unsigned quotient. When the second operand (in the active width) is zero, the result is 0.
- R6: Code 0x9 gives the unsigned remainder. When the second operand is zero, the result is the destination unchanged in 64-bit mode, and the destination's low 32 bits zero-extended in 32-bit mode.
- R7: Codes 0x4 (OR), 0x5 (AND), 0xa (XOR) and 0xb (move second operand) act bitwise.
- R8: Codes 0x6 (shift left) and 0x7 (logical shift right) use only the low 6 bits of the second operand as the shift count in 64-bit mode, and only the low 5 bits in 32-bit mode.
- R9: Code 0xc shifts right arithmetically with the same count masking. In 32-bit mode bit 31 is the sign bit, and bits 63:32 of the result are still 0.
- R10: Code 0x8 gives the two's-complement negation of the destination. The second operand has no effect.
- R11: Code 0xd reorders bytes of the destination only. `imm_val` of 16, 32 or 64 selects the width. `src_is_reg`=0 keeps the low bytes of that width unchanged. `src_is_reg`=1 reverses the byte order within that width. The bits above the width are 0. Neither `wide_mode` nor `src_val` has any effect.
- R12: Code 0xd with any other `imm_val`, and codes 0xe and 0xf, return the destination unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| src_is_reg | input | 1 | Second-operand select; byte-order direction for code 0xd |
| wide_mode | input | 1 | 1 = 64-bit, 0 = 32-bit |
| dst_val | input | 64 | Destination operand |
| src_val | input | 64 | Source register operand |
| imm_val | input | 32 | Immediate; swap width for code 0xd |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Value to write back to the destination |

## Verification
The bench focuses on the places where the two widths disagree.

- An all-ones immediate feeding an unsigned divide in each mode. A design that extended the immediate the same way in both modes would return 1 where 0 is expected, or the reverse.
- A zero divisor for both divide and remainder in both modes. A wrong design would produce X, all ones, or a remainder that keeps a stale upper half.
- Shift counts of 33 and 65. A design that did not mask the count would shift everything out.
- A 32-bit arithmetic shift of a negative low word whose upper half is nonzero. This catches a design that takes the sign from bit 63 or leaves the upper bits set.
- Every byte-swap width and direction, with `wide_mode` and `src_val` varied. This catches a design that truncates or reverses the wrong span.
- Idle cycles with changing inputs. These catch a result register that reloads without `in_valid`.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int unsigned EXU_XLEN  = 64;
  localparam int unsigned EXU_IMM_W = 32;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_MUL   = 4'h2,
    OP_DIV   = 4'h3,
    OP_OR    = 4'h4,
    OP_AND   = 4'h5,
    OP_LSH   = 4'h6,
    OP_RSH   = 4'h7,
    OP_NEG   = 4'h8,
    OP_MOD   = 4'h9,
    OP_XOR   = 4'ha,
    OP_MOV   = 4'hb,
    OP_ARSH  = 4'hc,
    OP_SWAP  = 4'hd,
    OP_RSV_E = 4'he,
    OP_RSV_F = 4'hf
  } exu_op_e;

endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int unsigned XLEN  = exu_pkg::EXU_XLEN,
  parameter int unsigned IMM_W = exu_pkg::EXU_IMM_W
) (
  input  logic             src_is_reg,
  input  logic             wide_mode,
  input  logic [XLEN-1:0]  src_val,
  input  logic [IMM_W-1:0] imm_val,
  output logic [XLEN-1:0]  opnd_b,
  output logic             b_full_zero,
  output logic             b_half_zero
);
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] imm_zext;

  assign imm_sext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
  assign imm_zext = {{EXT_W{1'b0}}, imm_val};

  always_comb begin
    if (src_is_reg)     opnd_b = src_val;
    else if (wide_mode) opnd_b = imm_sext;
    else                opnd_b = imm_zext;
  end

  assign b_full_zero = (opnd_b == '0);
  assign b_half_zero = (opnd_b[HALF-1:0] == '0);
endmodule

// File: rtl/exu_alu_lane.sv
module exu_alu_lane
  import exu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  exu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int unsigned SHW = $clog2(W);

  logic [SHW-1:0] sh_amt;
  assign sh_amt = b[SHW-1:0];

  function automatic logic [W-1:0] safe_div(input logic [W-1:0] n, input logic [W-1:0] d);
    if (d == '0) return '0;
    return n / d;
  endfunction

  function automatic logic [W-1:0] safe_rem(input logic [W-1:0] n, input logic [W-1:0] d);
    if (d == '0) return n;
    return n % d;
  endfunction

  function automatic logic [W-1:0] sra(input logic [W-1:0] v, input logic [SHW-1:0] n);
    logic signed [W-1:0] sv;
    sv = $signed(v);
    return $unsigned(sv >>> n);
  endfunction

  always_comb begin
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  res = safe_div(a, b);
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_LSH:  res = a << sh_amt;
      OP_RSH:  res = a >> sh_amt;
      OP_NEG:  res = '0 - a;
      OP_MOD:  res = safe_rem(a, b);
      OP_XOR:  res = a ^ b;
      OP_MOV:  res = b;
      OP_ARSH: res = sra(a, sh_amt);
      default: res = a;
    endcase
  end
endmodule

// File: rtl/exu_byte_swap.sv
module exu_byte_swap #(
  parameter int unsigned XLEN  = exu_pkg::EXU_XLEN,
  parameter int unsigned IMM_W = exu_pkg::EXU_IMM_W
) (
  input  logic [XLEN-1:0]  dst,
  input  logic             to_big,
  input  logic [IMM_W-1:0] width_sel,
  output logic [XLEN-1:0]  res
);
  localparam int unsigned MIN_W = 16;
  localparam int unsigned NWID  = $clog2(XLEN / MIN_W) + 1;

  logic [XLEN-1:0] cand [NWID];
  logic [NWID-1:0] hit;

  for (genvar gk = 0; gk < NWID; gk++) begin : g_width
    localparam int unsigned SW = MIN_W << gk;
    localparam int unsigned NB = SW / 8;
    logic [SW-1:0] rev;

    always_comb begin
      for (int i = 0; i < NB; i++) rev[8*i +: 8] = dst[8*(NB-1-i) +: 8];
    end

    assign cand[gk] = to_big ? XLEN'(rev) : XLEN'(dst[SW-1:0]);
    assign hit[gk]  = (width_sel == IMM_W'(SW));
  end

  always_comb begin
    res = dst;
    for (int k = 0; k < NWID; k++) if (hit[k]) res = cand[k];
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int unsigned XLEN  = EXU_XLEN,
  parameter int unsigned IMM_W = EXU_IMM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       op_code,
  input  logic             src_is_reg,
  input  logic             wide_mode,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [XLEN-1:0]  src_val,
  input  logic [IMM_W-1:0] imm_val,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_result
);
  localparam int unsigned HALF   = XLEN / 2;
  localparam int unsigned NLANES = 2;

  exu_op_e         op;
  logic [XLEN-1:0] opnd_b;
  logic            b_full_zero;
  logic            b_half_zero;
  logic [XLEN-1:0] lane_res [NLANES];
  logic [XLEN-1:0] swap_res;
  logic [XLEN-1:0] next_res;
  logic            divisor_zero;
  logic            is_reserved;

  assign op = exu_op_e'(op_code);

  exu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .src_is_reg (src_is_reg),
    .wide_mode  (wide_mode),
    .src_val    (src_val),
    .imm_val    (imm_val),
    .opnd_b     (opnd_b),
    .b_full_zero(b_full_zero),
    .b_half_zero(b_half_zero)
  );

  // lane 0 is full width, lane 1 is half width (zero-extended on exit)
  for (genvar gi = 0; gi < NLANES; gi++) begin : g_lane
    localparam int unsigned LW = XLEN >> gi;
    logic [LW-1:0] lane_out;
    exu_alu_lane #(.W(LW)) u_lane (
      .op (op),
      .a  (dst_val[LW-1:0]),
      .b  (opnd_b[LW-1:0]),
      .res(lane_out)
    );
    assign lane_res[gi] = XLEN'(lane_out);
  end

  exu_byte_swap #(.XLEN(XLEN), .IMM_W(IMM_W)) u_swap (
    .dst      (dst_val),
    .to_big   (src_is_reg),
    .width_sel(imm_val),
    .res      (swap_res)
  );

  assign is_reserved  = (op == OP_RSV_E) || (op == OP_RSV_F);
  assign divisor_zero = wide_mode ? b_full_zero : b_half_zero;

  always_comb begin
    if (op == OP_SWAP)  next_res = swap_res;
    else if (is_reserved) next_res = dst_val;
    else if (wide_mode) next_res = lane_res[0];
    else                next_res = lane_res[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_res;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));

  a_r3_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode && !(op == OP_SWAP) && !is_reserved)
      |=> (out_result[XLEN-1:HALF] == '0));

  a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DIV && divisor_zero) |=> (out_result == '0));

  a_r6_mod_zero_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MOD && wide_mode && b_full_zero)
      |=> (out_result == $past(dst_val)));

  a_r11_le16_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SWAP && !src_is_reg && imm_val == IMM_W'(16))
      |=> (out_result[XLEN-1:16] == '0));

  a_r12_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_reserved) |=> (out_result == $past(dst_val)));
endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic        src_is_reg;
  logic        wide_mode;
  logic [63:0] dst_val;
  logic [63:0] src_val;
  logic [31:0] imm_val;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [63:0] last_res;

  always #10 clk = ~clk;

  exu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_is_reg(src_is_reg), .wide_mode(wide_mode), .dst_val(dst_val),
    .src_val(src_val), .imm_val(imm_val), .out_valid(out_valid),
    .out_result(out_result)
  );

  function automatic logic [63:0] model(int op, bit sreg, bit wide,
                                        logic [63:0] d, logic [63:0] s, logic [31:0] imm);
    logic [63:0] b, r;
    logic [31:0] x, y, r32;
    b = sreg ? s : (wide ? {{32{imm[31]}}, imm} : {32'h0, imm});
    if (op == 13) begin
      if (imm == 16) return sreg ? {48'h0, d[7:0], d[15:8]} : {48'h0, d[15:0]};
      if (imm == 32) return sreg ? {32'h0, d[7:0], d[15:8], d[23:16], d[31:24]} : {32'h0, d[31:0]};
      if (imm == 64) begin
        r = {<<8{d}};
        return sreg ? r : d;
      end
      return d;
    end
    if (op >= 14) return d;
    if (wide) begin
      case (op)
        0: r = d + b;
        1: r = d - b;
        2: r = d * b;
        3: r = (b == 0) ? 64'h0 : d / b;
        4: r = d | b;
        5: r = d & b;
        6: r = d << b[5:0];
        7: r = d >> b[5:0];
        8: r = ~d + 64'h1;
        9: r = (b == 0) ? d : d % b;
        10: r = d ^ b;
        11: r = b;
        default: r = $signed(d) >>> b[5:0];
      endcase
      return r;
    end
    x = d[31:0];
    y = b[31:0];
    case (op)
      0: r32 = x + y;
      1: r32 = x - y;
      2: r32 = x * y;
      3: r32 = (y == 0) ? 32'h0 : x / y;
      4: r32 = x | y;
      5: r32 = x & y;
      6: r32 = x << y[4:0];
      7: r32 = x >> y[4:0];
      8: r32 = ~x + 32'h1;
      9: r32 = (y == 0) ? x : x % y;
      10: r32 = x ^ y;
      11: r32 = y;
      default: r32 = $signed(x) >>> y[4:0];
    endcase
    return {32'h0, r32};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation now (after a falling edge), compare at the next falling edge
  task automatic run(string tag, int op, bit sreg, bit wide,
                     logic [63:0] d, logic [63:0] s, logic [31:0] imm);
    logic [63:0] exp;
    exp = model(op, sreg, wide, d, s, imm);
    in_valid = 1'b1; op_code = op[3:0]; src_is_reg = sreg; wide_mode = wide;
    dst_val = d; src_val = s; imm_val = imm;
    @(negedge clk);
    check({tag, " R1 valid"}, {63'h0, out_valid}, 64'h1);
    check(tag, out_result, exp);
    last_res = exp;
  endtask

  task automatic idle(string tag);
    in_valid = 1'b0; op_code = 4'h2; src_is_reg = 1'b1; wide_mode = 1'b1;
    dst_val = {$urandom, $urandom}; src_val = {$urandom, $urandom}; imm_val = $urandom;
    @(negedge clk);
    check({tag, " valid low"}, {63'h0, out_valid}, 64'h0);
    check({tag, " hold"}, out_result, last_res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; src_is_reg = 1'b0; wide_mode = 1'b0;
    dst_val = '0; src_val = '0; imm_val = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'h0, out_valid}, 64'h0);
    check("R1 reset result", out_result, 64'h0);
    rst_n = 1'b1;
    last_res = '0;

    // R4 wrapping arithmetic
    run("R4 add64 wrap", 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
    run("R4 sub32 wrap", 1, 1, 0, 64'hABCD_0000_0000_0000, 64'h1, 0);
    run("R4 mul64", 2, 1, 1, 64'h1_0000_0001, 64'h1_0000_0001, 0);
    run("R4 mul32", 2, 0, 0, 64'h5555_0000_0001_0003, 0, 32'h8000_0001);
    // R2 immediate extension
    run("R2 add64 imm sext", 0, 0, 1, 64'h5, 64'h77, 32'hFFFF_FFFF);
    run("R2 add32 imm zext", 0, 0, 0, 64'h5, 64'h77, 32'hFFFF_FFFF);
    run("R2 div64 imm", 3, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF);
    run("R2 div64 imm small", 3, 0, 1, 64'hFFFF_FFFF, 0, 32'hFFFF_FFFF);
    run("R2 div32 imm", 3, 0, 0, 64'h1234_5678_FFFF_FFFE, 0, 32'hFFFF_FFFF);
    idle("R1 idle");
    // R5 / R6 zero divisor
    run("R5 div64 zero", 3, 1, 1, 64'hDEAD_BEEF_0000_0001, 64'h0, 0);
    run("R5 div32 zero low", 3, 1, 0, 64'h0000_0000_1000_0000, 64'hFFFF_FFFF_0000_0000, 0);
    run("R5 div64 normal", 3, 1, 1, 64'd1000, 64'd7, 0);
    run("R6 mod64 zero", 9, 0, 1, 64'hDEAD_BEEF_1234_5678, 0, 0);
    run("R6 mod32 zero", 9, 0, 0, 64'hDEAD_BEEF_1234_5678, 0, 0);
    run("R6 mod64 normal", 9, 1, 1, 64'd1000, 64'd7, 0);
    run("R6 mod32 normal", 9, 1, 0, 64'hFFFF_0000_0000_03E8, 64'd7, 0);
    // R7 logic and move
    run("R7 or", 4, 1, 1, 64'hF0F0, 64'h0F0F_0000_0000_0000, 0);
    run("R7 and32", 5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'h00FF_FF00);
    run("R7 xor", 10, 1, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 0);
    run("R7 mov64 imm", 11, 0, 1, 64'h1, 0, 32'h8000_0000);
    run("R7 mov32 imm", 11, 0, 0, 64'h1, 0, 32'h8000_0000);
    // R8 shift masking
    run("R8 lsh64 by65", 6, 1, 1, 64'h8000_0000_0000_0003, 64'd65, 0);
    run("R8 lsh32 by33", 6, 0, 0, 64'hFFFF_FFFF_C000_0003, 0, 32'd33);
    run("R8 rsh64", 7, 1, 1, 64'h8000_0000_0000_0000, 64'd63, 0);
    run("R8 rsh32 by36", 7, 0, 0, 64'hFFFF_FFFF_8000_0000, 0, 32'd36);
    // R9 arithmetic shift
    run("R9 arsh32", 12, 0, 0, 64'h1234_5678_8000_0000, 0, 32'd4);
    run("R9 arsh64", 12, 1, 1, 64'h8000_0000_0000_0000, 64'd68, 0);
    run("R9 arsh32 pos", 12, 1, 0, 64'hFFFF_FFFF_4000_0000, 64'd2, 0);
    // R10 negate ignores source
    run("R10 neg64", 8, 1, 1, 64'h1, 64'h1234, 0);
    run("R10 neg32", 8, 0, 0, 64'hFFFF_0000_0000_0002, 0, 32'h55);
    idle("R1 idle2");
    // R11 byte reorder
    run("R11 le16", 13, 0, 1, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd16);
    run("R11 be16", 13, 1, 0, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd16);
    run("R11 le32", 13, 0, 0, 64'h1122_3344_5566_7788, 64'h0, 32'd32);
    run("R11 be32", 13, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd32);
    run("R11 be64 narrow", 13, 1, 0, 64'h1122_3344_5566_7788, 64'h9999, 32'd64);
    run("R11 le64", 13, 0, 0, 64'h1122_3344_5566_7788, 64'h0, 32'd64);
    // R12 unsupported width and reserved codes
    run("R12 swap w8", 13, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd8);
    run("R12 op e", 14, 1, 0, 64'hCAFE_F00D_1234_5678, 64'h1, 0);
    run("R12 op f", 15, 0, 1, 64'hCAFE_F00D_1234_5678, 64'h1, 32'h7);

    // R3 and mixed: pseudo-random sweep over every code and both modes
    for (int n = 0; n < 3000; n++) begin
      int op;
      bit sreg, wide;
      logic [63:0] d, s;
      logic [31:0] imm;
      op = n % 16;
      sreg = $urandom_range(0, 1);
      wide = $urandom_range(0, 1);
      d = {$urandom, $urandom};
      s = {$urandom, $urandom};
      imm = $urandom;
      if (n % 7 == 0) s = 64'h0;
      if (n % 11 == 0) imm = 32'h0;
      if (n % 5 == 0) s = s & 64'hFF;
      if (op == 13) imm = 32'd16 << $urandom_range(0, 2);
      run(wide ? "R3 sweep64" : "R3 sweep32", op, sreg, wide, d, s, imm);
      if (n % 97 == 0) idle("R1 sweep idle");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule